// File: doc/BRIEF.md
# Indexed Register Address/Data Ports

This unit gives a host indirect access to two banks of registers through three I/O locations. One address-pointer location holds an index. Two data locations use that same index: the first reaches a control/status bank and the second reaches a bus-configuration bank. To access a register, the host first loads the pointer and then reads or writes through the data location for the bank it wants.

The unit works in a 16-bit word mode or a 32-bit doubleword mode, selected by a static input, and it honours per-byte write enables. In doubleword mode the upper half of the pointer and of every register is reserved and reads as zero. The one exception is control/status entry 88, which stores a full 32 bits. A hard reset clears everything. A soft reset clears only the pointer. Read data is registered and appears the cycle after the read strobe.

Top module: `regport_idx_unit`

## Requirements
- R1: After hard reset (`rst_n` low) the pointer, every register in both banks and `rdata` are zero.
- R2: A write with `port_sel`=0 loads the pointer from the enabled low two bytes of `wdata`. A read with `port_sel`=0 returns the 16-bit pointer with `rdata[31:16]` zero.
- R3: The pointer keeps its value across data-port reads and writes and across idle cycles. It changes only on a pointer write or a reset.
- R4: A one-cycle `soft_rst` pulse clears the pointer to zero and leaves the contents of both banks unchanged.
- R5: `port_sel`=1 reads or writes control/status entry `pointer[6:0]`. Pointer bits 15:7 are ignored when indexing.
- R6: `port_sel`=2 reads or writes bus-configuration entry `pointer[6:0]`. This is a separate bank: writes to one bank never change the other.
- R7: A write updates only the bytes whose `byte_en` bit is set (bit k covers `wdata[8k+7:8k]`). A write with no enable set changes nothing.
- R8: In word mode (`dword_mode`=0), `byte_en[3:2]` are ignored and every read returns zero in `rdata[31:16]`, including entry 88.
- R9: In doubleword mode, writes to bytes 2–3 are dropped and those bytes read back as zero for every register except control/status entry 88. Entry 88 stores and returns all 32 bits.
- R10: `rdata` takes its new value at the clock edge that samples `rd_en` high, and it holds that value in every cycle without a read.
- R11: `port_sel`=3 selects nothing. A write there changes no state, and a read there returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous hard reset |
| soft_rst | input | 1 | Synchronous soft reset; clears the pointer only |
| dword_mode | input | 1 | 1 = 32-bit doubleword mode, 0 = 16-bit word mode |
| port_sel | input | 2 | 0 pointer, 1 control/status data, 2 bus-configuration data, 3 none |
| wr_en | input | 1 | Write strobe for the selected location |
| rd_en | input | 1 | Read strobe for the selected location |
| byte_en | input | 4 | Per-byte write enables |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high in the same cycle. They also assume that `dword_mode` and `port_sel` stay steady while a strobe is high. The stimulus respects this by driving every input on the falling clock edge. Each task raises exactly one strobe for exactly one cycle. Mode changes are made only between accesses.

// File: rtl/rpi_pkg.sv
package rpi_pkg;
   typedef enum logic [1:0] {
      PSEL_PTR  = 2'd0,
      PSEL_CSR  = 2'd1,
      PSEL_BCR  = 2'd2,
      PSEL_NONE = 2'd3
   } psel_e;
endpackage

// File: rtl/rpi_lane_mask.sv
module rpi_lane_mask #(
   parameter int DATA_W = 32
) (
   input  logic                  dword_mode,
   input  logic [DATA_W/8-1:0]   be_in,
   output logic [DATA_W/8-1:0]   be_out
);
   localparam int LANES = DATA_W / 8;
   localparam int HALF_LANES = LANES / 2;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      if (k < HALF_LANES) begin : g_low
         assign be_out[k] = be_in[k];
      end else begin : g_high
         assign be_out[k] = be_in[k] & dword_mode;
      end
   end
endmodule

// File: rtl/rpi_pointer.sv
module rpi_pointer #(
   parameter int DATA_W = 32,
   parameter int PTR_W  = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  soft_rst,
   input  logic                  we,
   input  logic [DATA_W/8-1:0]   eff_be,
   input  logic [DATA_W-1:0]     wdata,
   output logic [PTR_W-1:0]      ptr_q
);
   localparam int PTR_LANES = PTR_W / 8;

   if (PTR_W % 8 != 0 || PTR_W > DATA_W) begin : g_bad_ptr
      $error("rpi_pointer: PTR_W must be a byte multiple no wider than DATA_W");
   end

   logic unused_hi;
   assign unused_hi = ^{wdata[DATA_W-1:PTR_W], eff_be[DATA_W/8-1:PTR_LANES]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (soft_rst) begin
         ptr_q <= '0;
      end else if (we) begin
         for (int l = 0; l < PTR_LANES; l++) begin
            if (eff_be[l]) ptr_q[l*8 +: 8] <= wdata[l*8 +: 8];
         end
      end
   end

   // R3
   ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!soft_rst && !we) |=> $stable(ptr_q));

   // R4
   ptr_soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (ptr_q == '0));
endmodule

// File: rtl/rpi_bank.sv
module rpi_bank #(
   parameter int DATA_W   = 32,
   parameter int IDX_W    = 7,
   parameter bit HAS_WIDE = 1'b0,
   parameter int WIDE_IDX = 88
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we,
   input  logic [IDX_W-1:0]      idx,
   input  logic [DATA_W/8-1:0]   eff_be,
   input  logic [DATA_W-1:0]     wdata,
   output logic [DATA_W-1:0]     rd_word
);
   localparam int DEPTH   = 1 << IDX_W;
   localparam int HALF_W  = DATA_W / 2;
   localparam int LO_LANES = HALF_W / 8;

   if (WIDE_IDX < 0 || WIDE_IDX >= DEPTH) begin : g_bad_wide
      $error("rpi_bank: WIDE_IDX outside the bank");
   end

   logic [HALF_W-1:0] lo_mem [DEPTH];
   logic [HALF_W-1:0] hi_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < DEPTH; e++) lo_mem[e] <= '0;
      end else if (we) begin
         for (int l = 0; l < LO_LANES; l++) begin
            if (eff_be[l]) lo_mem[idx][l*8 +: 8] <= wdata[l*8 +: 8];
         end
      end
   end

   if (HAS_WIDE) begin : g_wide
      logic [HALF_W-1:0] hi_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hi_q <= '0;
         end else if (we && idx == IDX_W'(WIDE_IDX)) begin
            for (int l = 0; l < LO_LANES; l++) begin
               if (eff_be[LO_LANES+l]) hi_q[l*8 +: 8] <= wdata[HALF_W + l*8 +: 8];
            end
         end
      end
      assign hi_word = (idx == IDX_W'(WIDE_IDX)) ? hi_q : '0;
   end else begin : g_narrow
      logic unused_hi;
      assign unused_hi = ^{wdata[DATA_W-1:HALF_W], eff_be[DATA_W/8-1:LO_LANES]};
      assign hi_word = '0;
   end

   assign rd_word = {hi_word, lo_mem[idx]};

   // R5
   bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> (idx != $past(idx) || $stable(rd_word)));
endmodule

// File: rtl/regport_idx_unit.sv
module regport_idx_unit #(
   parameter int DATA_W   = 32,
   parameter int PTR_W    = 16,
   parameter int IDX_W    = 7,
   parameter int WIDE_IDX = 88
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          soft_rst,
   input  logic          dword_mode,
   input  logic [1:0]    port_sel,
   input  logic          wr_en,
   input  logic          rd_en,
   input  logic [3:0]    byte_en,
   input  logic [31:0]   wdata,
   output logic [31:0]   rdata
);
   import rpi_pkg::*;

   localparam int LANES  = DATA_W / 8;
   localparam int HALF_W = DATA_W / 2;

   if (DATA_W != 32) begin : g_bad_width
      $error("regport_idx_unit: DATA_W must be 32");
   end
   if (IDX_W > PTR_W) begin : g_bad_idx
      $error("regport_idx_unit: IDX_W exceeds PTR_W");
   end
   if (PTR_W != HALF_W) begin : g_bad_ptr
      $error("regport_idx_unit: PTR_W must be half of DATA_W");
   end

   psel_e             psel;
   logic [LANES-1:0]  eff_be;
   logic [PTR_W-1:0]  ptr_q;
   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] csr_word, bcr_word, rd_next, rdata_q;
   logic              ptr_we, csr_we, bcr_we;

   assign psel   = psel_e'(port_sel);
   assign idx    = ptr_q[IDX_W-1:0];
   assign ptr_we = wr_en && psel == PSEL_PTR;
   assign csr_we = wr_en && psel == PSEL_CSR;
   assign bcr_we = wr_en && psel == PSEL_BCR;

   rpi_lane_mask #(.DATA_W(DATA_W)) u_mask (
      .dword_mode (dword_mode),
      .be_in      (byte_en),
      .be_out     (eff_be)
   );

   rpi_pointer #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .we       (ptr_we),
      .eff_be   (eff_be),
      .wdata    (wdata),
      .ptr_q    (ptr_q)
   );

   rpi_bank #(.DATA_W(DATA_W), .IDX_W(IDX_W), .HAS_WIDE(1'b1), .WIDE_IDX(WIDE_IDX)) u_csr (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (csr_we),
      .idx     (idx),
      .eff_be  (eff_be),
      .wdata   (wdata),
      .rd_word (csr_word)
   );

   rpi_bank #(.DATA_W(DATA_W), .IDX_W(IDX_W), .HAS_WIDE(1'b0), .WIDE_IDX(WIDE_IDX)) u_bcr (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (bcr_we),
      .idx     (idx),
      .eff_be  (eff_be),
      .wdata   (wdata),
      .rd_word (bcr_word)
   );

   always_comb begin
      unique case (psel)
         PSEL_PTR: rd_next = {{(DATA_W-PTR_W){1'b0}}, ptr_q};
         PSEL_CSR: rd_next = csr_word;
         PSEL_BCR: rd_next = bcr_word;
         default:  rd_next = '0;
      endcase
      if (!dword_mode) rd_next[DATA_W-1:HALF_W] = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (rd_en)  rdata_q <= rd_next;
   end

   assign rdata = rdata_q;

   // R10 (input contract: one strobe at a time)
   one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && rd_en));

   // R10
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));

   // R8
   word_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !dword_mode) |=> (rdata[31:16] == 16'h0));

   // R11
   null_port_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && port_sel == 2'd3) |=> (rdata == 32'h0));
endmodule

// File: tb/tb_regport_idx_unit.sv
module tb_regport_idx_unit;
   logic        clk = 1'b0;
   logic        rst_n, soft_rst, dword_mode, wr_en, rd_en;
   logic [1:0]  port_sel;
   logic [3:0]  byte_en;
   logic [31:0] wdata, rdata;

   int n_chk = 0;
   int n_fail = 0;

   logic [31:0] csr_m [128];
   logic [31:0] bcr_m [128];
   logic [15:0] ptr_m;

   always #2 clk = ~clk;

   regport_idx_unit dut (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .dword_mode(dword_mode),
      .port_sel(port_sel), .wr_en(wr_en), .rd_en(rd_en), .byte_en(byte_en),
      .wdata(wdata), .rdata(rdata)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic put(input logic [1:0] sel, input logic [3:0] be, input logic [31:0] d);
      logic [3:0] eb;
      logic [6:0] ix;
      eb = dword_mode ? be : (be & 4'b0011);
      ix = ptr_m[6:0];
      for (int l = 0; l < 4; l++) begin
         if (eb[l]) begin
            if (sel == 2'd0 && l < 2) ptr_m[l*8 +: 8] = d[l*8 +: 8];
            if (sel == 2'd1 && (l < 2 || ix == 7'd88)) csr_m[ix][l*8 +: 8] = d[l*8 +: 8];
            if (sel == 2'd2 && l < 2) bcr_m[ix][l*8 +: 8] = d[l*8 +: 8];
         end
      end
      wr_en = 1'b1; port_sel = sel; byte_en = be; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; byte_en = 4'h0; wdata = 32'h0;
   endtask

   task automatic get(input logic [1:0] sel, input string tag);
      logic [31:0] e;
      case (sel)
         2'd0: e = {16'h0, ptr_m};
         2'd1: e = csr_m[ptr_m[6:0]];
         2'd2: e = bcr_m[ptr_m[6:0]];
         default: e = 32'h0;
      endcase
      if (!dword_mode) e[31:16] = 16'h0;
      rd_en = 1'b1; port_sel = sel;
      @(negedge clk);
      rd_en = 1'b0;
      check(tag, rdata, e);
   endtask

   initial begin
      #(4 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] hold;
      for (int i = 0; i < 128; i++) begin csr_m[i] = 32'h0; bcr_m[i] = 32'h0; end
      ptr_m = 16'h0;
      rst_n = 1'b0; soft_rst = 1'b0; dword_mode = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
      port_sel = 2'd0; byte_en = 4'h0; wdata = 32'h0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 rdata", rdata, 32'h0);
      get(2'd0, "R1 pointer");
      dword_mode = 1'b1;
      put(2'd0, 4'hF, 32'd88);
      get(2'd1, "R1 csr88");
      get(2'd2, "R1 bcr88");
      put(2'd0, 4'hF, 32'd0);
      dword_mode = 1'b0;

      // Sweeps in both modes: R5, R6, R8, R9
      for (int m = 0; m < 2; m++) begin
         dword_mode = m[0];
         for (int i = 0; i < 128; i++) begin
            put(2'd0, 4'hF, 32'hA5A5_0000 | i);
            put(2'd1, 4'hF, {16'h3C00 + 16'(i*7), 16'h1000 + 16'(i*37 + m*5)});
            put(2'd2, 4'hF, {16'h7E00 + 16'(i*3), 16'h8000 + 16'(i*91 + m*11)});
         end
         for (int i = 0; i < 128; i++) begin
            put(2'd0, 4'hF, 32'(i + 128 * (i % 5)));
            get(2'd1, m ? "R9 csr sweep" : "R8 csr sweep");
            get(2'd2, "R6 bcr sweep");
         end
         get(2'd0, "R2 pointer readback");
         get(2'd0, "R3 pointer after data accesses");
      end

      // R7 byte enables, both modes, entry 3 and entry 88
      for (int m = 0; m < 2; m++) begin
         dword_mode = m[0];
         for (int t = 0; t < 2; t++) begin
            put(2'd0, 4'h3, t ? 32'd88 : 32'd3);
            for (int b = 0; b < 16; b++) begin
               put(2'd1, 4'(b), 32'h1122_3344 + 32'(b) * 32'h0101_0101);
               get(2'd1, "R7 csr byte enables");
               put(2'd2, 4'(b), 32'h5566_7788 + 32'(b) * 32'h0102_0304);
               get(2'd2, "R7 bcr byte enables");
            end
         end
      end

      // R9 explicit values
      dword_mode = 1'b1;
      put(2'd0, 4'hF, 32'd88);
      put(2'd1, 4'hF, 32'hCAFE_F00D);
      rd_en = 1'b1; port_sel = 2'd1; @(negedge clk); rd_en = 1'b0;
      check("R9 csr88 full word", rdata, 32'hCAFE_F00D);
      put(2'd0, 4'hF, 32'd87);
      put(2'd1, 4'hF, 32'hDEAD_BEEF);
      rd_en = 1'b1; port_sel = 2'd1; @(negedge clk); rd_en = 1'b0;
      check("R9 csr87 upper dropped", rdata, 32'h0000_BEEF);
      // R2 upper pointer bits reserved
      put(2'd0, 4'hF, 32'hFFFF_0042);
      rd_en = 1'b1; port_sel = 2'd0; @(negedge clk); rd_en = 1'b0;
      check("R2 pointer upper zero", rdata, 32'h0000_0042);

      // R8 entry 88 upper hidden in word mode
      dword_mode = 1'b0;
      put(2'd0, 4'hF, 32'd88);
      get(2'd1, "R8 csr88 word mode");

      // R10 hold without reads
      rd_en = 1'b1; port_sel = 2'd2; @(negedge clk); rd_en = 1'b0;
      hold = rdata;
      put(2'd2, 4'hF, 32'h0000_1234);
      repeat (3) @(negedge clk);
      check("R10 rdata held", rdata, hold);
      get(2'd2, "R10 new read");

      // R11 null port
      dword_mode = 1'b1;
      put(2'd0, 4'hF, 32'd9);
      put(2'd3, 4'hF, 32'h9999_9999);
      get(2'd3, "R11 null read");
      get(2'd0, "R11 pointer untouched");
      get(2'd1, "R11 csr untouched");
      get(2'd2, "R11 bcr untouched");

      // R4 soft reset
      put(2'd0, 4'hF, 32'd77);
      soft_rst = 1'b1; @(negedge clk); soft_rst = 1'b0;
      ptr_m = 16'h0;
      get(2'd0, "R4 pointer cleared");
      get(2'd1, "R4 csr0 kept");
      get(2'd2, "R4 bcr0 kept");
      put(2'd0, 4'hF, 32'd88);
      get(2'd1, "R4 csr88 kept");
      put(2'd0, 4'hF, 32'd77);
      get(2'd1, "R4 csr77 kept");

      // R1 hard reset mid-run
      rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
      for (int i = 0; i < 128; i++) begin csr_m[i] = 32'h0; bcr_m[i] = 32'h0; end
      ptr_m = 16'h0;
      check("R1 rdata after hard reset", rdata, 32'h0);
      get(2'd0, "R1 pointer after hard reset");
      put(2'd0, 4'hF, 32'd88);
      get(2'd1, "R1 csr88 after hard reset");
      get(2'd2, "R1 bcr88 after hard reset");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule